// File: doc/BRIEF.md
# Flash Command Controller Register Front End

This block is the register-facing half of an embedded flash controller. It sits on a simple word-wide register bus and holds a clock-divider register, a configuration register, two protection registers, a command register and a status register. Software first loads the divider. It then writes one data word into the array window, which latches that word and its array address. Next it writes a command code and launches the command by setting the start bit in the status register.

An accepted command keeps the controller busy for a fixed number of divided-clock ticks. Launches that cannot run are refused at once. A refused launch sets an access-error or a protection-violation flag, and both flags clear when a one is written to their bit. A small state bit records whether a program operation has completed since the last erase. The erase-verify command reports that state through the blank flag. There is no real array behind the block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status register (offset 0x05) reads 0x40. The divider register (0x00) and the command register (0x04) read 0x00.
- R2: The divider register holds a 7-bit divisor in bits 6:0. After the first accepted write, bit 7 reads 1 and stays 1 until reset.
- R3: While configuration bit 7 (offset 0x01) is 1, writes to the divider register are ignored.
- R4: A start write (status bit 7) is refused if the divider was never loaded, if no array word is latched, or if the command code is not one of 0x05 (erase verify), 0x20 (program), 0x40 (page erase) or 0x41 (mass erase). A refused start sets access error (status bit 4), and status bit 6 (idle) stays 1.
- R5: Protect-A bit n (offset 0x02) guards sector n, which is array address bits 6:4. A program or page erase whose latched address lies in a guarded sector is refused. A mass erase is refused while either protection register (0x02, 0x03) is nonzero. A refusal sets protection violation (status bit 5) and idle stays 1. When both registers are zero, nothing is guarded.
- R6: An accepted command clears idle for exactly EXEC_TICKS*(divisor+1) cycles, counted from the clock edge that takes the start write.
- R7: A start write while a command is busy is ignored. The busy time does not change and no flag is set.
- R8: Writing 1 to status bit 5, 4 or 2 clears that flag. Writing 0 to a flag bit leaves the flag unchanged.
- R9: An accepted command clears the blank flag (status bit 2). When erase verify completes, the blank flag is set if no program command has completed since the last page or mass erase or since reset.
- R10: A write to an address with bit 7 set latches the data word and the array address (bits 6:0). Reading any array-window address returns the latched data word, and offset 0x06 returns the latched address. An accepted command consumes the latched pair, so a later start without a new latch is refused with access error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the current address |
| addr_i | input | ADDR_W | Register offset, or array window when the top bit is set |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |

## Verification
The bench measures the busy window for every divisor from 0 to 7. Each divisor runs a fixed series of commands that moves the modelled array between programmed and erased. This separates errors in tick counting from errors in prescaler reload, and checks when the blank flag is set and cleared. A sweep over all 64 pairs of guarded sector and target sector shows whether sector decoding picks the right protection bit. The refusal cases are each tried on their own: unloaded divider, missing latch, bad code, and mass erase under each protection register. A restart during busy shows whether a second start is truly ignored or silently restarts the timer.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int REG_W    = 8;
  localparam int OFF_DIV  = 0;
  localparam int OFF_CFG  = 1;
  localparam int OFF_PRA  = 2;
  localparam int OFF_PRB  = 3;
  localparam int OFF_CMD  = 4;
  localparam int OFF_STAT = 5;
  localparam int OFF_LADR = 6;

  localparam int ST_START  = 7;
  localparam int ST_IDLE   = 6;
  localparam int ST_PVIOL  = 5;
  localparam int ST_ACCERR = 4;
  localparam int ST_BLANK  = 2;
  localparam int CFG_LOCK  = 7;

  typedef enum logic [7:0] {
    CMD_VERIFY = 8'h05,
    CMD_PROG   = 8'h20,
    CMD_PERASE = 8'h40,
    CMD_MERASE = 8'h41
  } cmd_e;

  typedef enum logic [1:0] {
    LR_OK     = 2'd0,
    LR_ACCERR = 2'd1,
    LR_PVIOL  = 2'd2
  } launch_res_e;
endpackage

// File: rtl/flash_reg_file.sv
module flash_reg_file
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int PROT_W = 8,
  parameter int DIV_W  = 7,
  localparam int ARR_W  = ADDR_W - 1,
  localparam int SECT_W = $clog2(PROT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              accept_i,
  input  logic [REG_W-1:0]  status_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              div_loaded_o,
  output logic [PROT_W-1:0] prot_a_o,
  output logic [PROT_W-1:0] prot_b_o,
  output logic [REG_W-1:0]  cmd_o,
  output logic [SECT_W-1:0] latch_sect_o,
  output logic              latch_valid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DIV_W-1:0]  div_q;
  logic              loaded_q;
  logic [REG_W-1:0]  cfg_q;
  logic [PROT_W-1:0] pra_q, prb_q;
  logic [REG_W-1:0]  cmd_q;
  logic [ARR_W-1:0]  ladr_q;
  logic [DATA_W-1:0] ldat_q;
  logic              lvalid_q;

  logic win_wr;
  assign win_wr = wr_i && addr_i[ADDR_W-1];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      loaded_q <= 1'b0;
      cfg_q    <= '0;
      pra_q    <= '0;
      prb_q    <= '0;
      cmd_q    <= '0;
    end else if (wr_i) begin
      if (hit(addr_i, OFF_DIV) && !cfg_q[CFG_LOCK]) begin
        div_q    <= wdata_i[DIV_W-1:0];
        loaded_q <= 1'b1;
      end
      if (hit(addr_i, OFF_CFG)) cfg_q <= wdata_i[REG_W-1:0];
      if (hit(addr_i, OFF_PRA)) pra_q <= wdata_i[PROT_W-1:0];
      if (hit(addr_i, OFF_PRB)) prb_q <= wdata_i[PROT_W-1:0];
      if (hit(addr_i, OFF_CMD)) cmd_q <= wdata_i[REG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ladr_q   <= '0;
      ldat_q   <= '0;
      lvalid_q <= 1'b0;
    end else if (win_wr) begin
      ladr_q   <= addr_i[ARR_W-1:0];
      ldat_q   <= wdata_i;
      lvalid_q <= 1'b1;
    end else if (accept_i) begin
      lvalid_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1]) begin
      rdata_o = ldat_q;
    end else begin
      case (addr_i)
        ADDR_W'(OFF_DIV):  rdata_o = DATA_W'({loaded_q, div_q});
        ADDR_W'(OFF_CFG):  rdata_o = DATA_W'(cfg_q);
        ADDR_W'(OFF_PRA):  rdata_o = DATA_W'(pra_q);
        ADDR_W'(OFF_PRB):  rdata_o = DATA_W'(prb_q);
        ADDR_W'(OFF_CMD):  rdata_o = DATA_W'(cmd_q);
        ADDR_W'(OFF_STAT): rdata_o = DATA_W'(status_i);
        ADDR_W'(OFF_LADR): rdata_o = DATA_W'(ladr_q);
        default:           rdata_o = '0;
      endcase
    end
  end

  assign div_o         = div_q;
  assign div_loaded_o  = loaded_q;
  assign prot_a_o      = pra_q;
  assign prot_b_o      = prb_q;
  assign cmd_o         = cmd_q;
  assign latch_sect_o  = ladr_q[ARR_W-1 -: SECT_W];
  assign latch_valid_o = lvalid_q;
endmodule

// File: rtl/flash_launch_check.sv
module flash_launch_check
  import flash_cmd_pkg::*;
#(
  parameter int PROT_W = 8,
  localparam int SECT_W = $clog2(PROT_W)
) (
  input  logic [REG_W-1:0]  cmd_i,
  input  logic              div_loaded_i,
  input  logic              latch_valid_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [PROT_W-1:0] prot_a_i,
  input  logic [PROT_W-1:0] prot_b_i,
  output launch_res_e       res_o
);
  logic code_ok, guarded;

  always_comb begin
    code_ok = 1'b0;
    guarded = 1'b0;
    case (cmd_i)
      CMD_VERIFY: code_ok = 1'b1;
      CMD_PROG, CMD_PERASE: begin
        code_ok = 1'b1;
        guarded = prot_a_i[sect_i];
      end
      CMD_MERASE: begin
        code_ok = 1'b1;
        guarded = (|prot_a_i) || (|prot_b_i);
      end
      default: ;
    endcase
    if (!div_loaded_i || !latch_valid_i || !code_ok) res_o = LR_ACCERR;
    else if (guarded)                                res_o = LR_PVIOL;
    else                                             res_o = LR_OK;
  end
endmodule

// File: rtl/flash_exec_timer.sv
module flash_exec_timer #(
  parameter int EXEC_TICKS = 4,
  parameter int DIV_W      = 7,
  localparam int TCNT_W = (EXEC_TICKS > 1) ? $clog2(EXEC_TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [TCNT_W-1:0] LAST = TCNT_W'(EXEC_TICKS - 1);

  logic [DIV_W-1:0]  pre_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic              busy_q;
  logic              tick;

  assign tick = busy_q && (pre_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tcnt_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        pre_q  <= '0;
        tcnt_q <= '0;
      end
    end else if (tick) begin
      pre_q <= '0;
      if (tcnt_q == LAST) begin
        busy_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = tick && (tcnt_q == LAST);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int EXEC_TICKS = 4,
  parameter int PROT_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DIV_W  = 7;
  localparam int SECT_W = $clog2(PROT_W);

  logic [DIV_W-1:0]  div_q;
  logic              div_loaded;
  logic [PROT_W-1:0] prot_a, prot_b;
  logic [REG_W-1:0]  cmd_q;
  logic [SECT_W-1:0] latch_sect;
  logic              latch_valid;
  logic [REG_W-1:0]  status;
  launch_res_e       res;
  logic              busy, done;
  logic              stat_wr, start_wr, launch_try, accept;
  logic              pviol_q, accerr_q, blank_q, dirty_q;
  logic [REG_W-1:0]  run_cmd_q;

  assign stat_wr    = wr_i && (addr_i == ADDR_W'(OFF_STAT));
  assign start_wr   = stat_wr && wdata_i[ST_START];
  assign launch_try = start_wr && !busy;
  assign accept     = launch_try && (res == LR_OK);

  flash_reg_file #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_W(PROT_W), .DIV_W(DIV_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .accept_i     (accept),
    .status_i     (status),
    .div_o        (div_q),
    .div_loaded_o (div_loaded),
    .prot_a_o     (prot_a),
    .prot_b_o     (prot_b),
    .cmd_o        (cmd_q),
    .latch_sect_o (latch_sect),
    .latch_valid_o(latch_valid),
    .rdata_o      (rdata_o)
  );

  flash_launch_check #(.PROT_W(PROT_W)) u_check (
    .cmd_i        (cmd_q),
    .div_loaded_i (div_loaded),
    .latch_valid_i(latch_valid),
    .sect_i       (latch_sect),
    .prot_a_i     (prot_a),
    .prot_b_i     (prot_b),
    .res_o        (res)
  );

  flash_exec_timer #(.EXEC_TICKS(EXEC_TICKS), .DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .div_i  (div_q),
    .busy_o (busy),
    .done_o (done)
  );

  // flags: write-one-to-clear first, then set by this cycle's event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pviol_q   <= 1'b0;
      accerr_q  <= 1'b0;
      blank_q   <= 1'b0;
      dirty_q   <= 1'b0;
      run_cmd_q <= '0;
    end else begin
      pviol_q  <= (pviol_q  && !(stat_wr && wdata_i[ST_PVIOL]))
                  || (launch_try && res == LR_PVIOL);
      accerr_q <= (accerr_q && !(stat_wr && wdata_i[ST_ACCERR]))
                  || (launch_try && res == LR_ACCERR);
      blank_q  <= (blank_q && !(stat_wr && wdata_i[ST_BLANK]) && !accept)
                  || (done && run_cmd_q == CMD_VERIFY && !dirty_q);
      if (accept) run_cmd_q <= cmd_q;
      if (done) begin
        if (run_cmd_q == CMD_PROG) dirty_q <= 1'b1;
        else if (run_cmd_q == CMD_PERASE || run_cmd_q == CMD_MERASE) dirty_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status            = '0;
    status[ST_IDLE]   = !busy;
    status[ST_PVIOL]  = pviol_q;
    status[ST_ACCERR] = accerr_q;
    status[ST_BLANK]  = blank_q;
  end
endmodule

// File: rtl/flash_cmd_ctrl_sva.sv
module flash_cmd_ctrl_sva
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIV_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit7_i,
  input logic              busy_i,
  input logic              div_loaded_i,
  input logic [DIV_W-1:0]  div_i,
  input logic              pviol_i,
  input logic              accerr_i
);
  logic lock_q;
  logic start_wr, div_wr;

  assign start_wr = wr_i && addr_i == ADDR_W'(OFF_STAT) && wbit7_i;
  assign div_wr   = wr_i && addr_i == ADDR_W'(OFF_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (wr_i && addr_i == ADDR_W'(OFF_CFG)) lock_q <= wbit7_i;
  end

  p_div_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_loaded_i |=> div_loaded_i);

  p_div_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_wr && lock_q) |=> $stable(div_i));

  p_unloaded_refused_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr && !busy_i && !div_loaded_i) |=> (!busy_i && accerr_i));

  p_pviol_stays_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pviol_i) |-> !busy_i);

  p_busy_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr && busy_i) |=> (!$rose(accerr_i) && !$rose(pviol_i)));

  p_accerr_needs_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accerr_i) |-> $past(wr_i));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_sva #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .wbit7_i     (wdata_i[7]),
  .busy_i      (busy),
  .div_loaded_i(div_loaded),
  .div_i       (div_q),
  .pviol_i     (pviol_q),
  .accerr_i    (accerr_q)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int TICKS  = 4;

  localparam logic [7:0] A_DIV = 8'h00, A_CFG = 8'h01, A_PRA = 8'h02, A_PRB = 8'h03;
  localparam logic [7:0] A_CMD = 8'h04, A_STAT = 8'h05, A_LADR = 8'h06;
  localparam logic [7:0] C_VER = 8'h05, C_PROG = 8'h20, C_PERA = 8'h40, C_MERA = 8'h41;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXEC_TICKS(TICKS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output int v);
    addr = a; #1;
    v = int'(rdata);
  endtask

  // start write, then count cycles with idle low
  task automatic launch_measure(output int n);
    wr_reg(A_STAT, 16'h0080);
    addr = A_STAT; #1;
    n = 0;
    while (!rdata[6] && n < 2000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic prep(input logic [7:0] cmd, input logic [6:0] aa);
    wr_reg({1'b1, aa}, 16'hA5C3);
    wr_reg(A_CMD, {8'h00, cmd});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v, n;
    logic dirty;
    logic [7:0] seq [7];
    seq[0] = C_PROG; seq[1] = C_VER; seq[2] = C_PERA; seq[3] = C_VER;
    seq[4] = C_PROG; seq[5] = C_MERA; seq[6] = C_VER;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_reg(A_STAT, v); chk("R1 status", v, 'h40);
    rd_reg(A_DIV, v);  chk("R1 div", v, 'h00);
    rd_reg(A_CMD, v);  chk("R1 cmd", v, 'h00);

    // R4: divider never loaded
    prep(C_PROG, 7'h00);
    wr_reg(A_STAT, 16'h0080);
    rd_reg(A_STAT, v); chk("R4 unloaded", v, 'h50);
    // R8: zero in flag bit or other flag bit does not clear
    wr_reg(A_STAT, 16'h0020);
    rd_reg(A_STAT, v); chk("R8 keep", v, 'h50);
    wr_reg(A_STAT, 16'h0010);
    rd_reg(A_STAT, v); chk("R8 clear", v, 'h40);

    // R2 divider readback and sticky bit
    wr_reg(A_DIV, 16'h0085);
    rd_reg(A_DIV, v); chk("R2 load", v, 'h85);
    wr_reg(A_DIV, 16'h0003);
    rd_reg(A_DIV, v); chk("R2 sticky", v, 'h83);
    // R3 lock
    wr_reg(A_CFG, 16'h0080);
    wr_reg(A_DIV, 16'h0007);
    rd_reg(A_DIV, v); chk("R3 locked", v, 'h83);
    wr_reg(A_CFG, 16'h0000);
    wr_reg(A_DIV, 16'h0001);
    rd_reg(A_DIV, v); chk("R3 unlocked", v, 'h81);

    // R4 bad code; R10 window readback
    prep(8'h33, 7'h15);
    rd_reg(8'hFF, v);  chk("R10 data", v, 'hA5C3);
    rd_reg(A_LADR, v); chk("R10 addr", v, 'h15);
    wr_reg(A_STAT, 16'h0080);
    rd_reg(A_STAT, v); chk("R4 bad code", v, 'h50);
    wr_reg(A_STAT, 16'h0010);

    // R10 latch consumed by accepted command
    wr_reg(A_CMD, {8'h00, C_VER});
    launch_measure(n); chk("R6 first", n, TICKS * 2);
    wr_reg(A_STAT, 16'h0084);
    launch_measure(n); chk("R10 consumed no busy", n, 0);
    rd_reg(A_STAT, v); chk("R10 consumed", v, 'h50);
    wr_reg(A_STAT, 16'h0010);

    // R6/R9 sweep over divisors and command series
    dirty = 1'b0;
    for (int d = 0; d < 8; d++) begin
      wr_reg(A_DIV, 16'(d));
      for (int i = 0; i < 7; i++) begin
        prep(seq[i], 7'(i * 16));
        launch_measure(n);
        chk($sformatf("R6 d=%0d i=%0d", d, i), n, TICKS * (d + 1));
        if (seq[i] == C_PROG) dirty = 1'b1;
        if (seq[i] == C_PERA || seq[i] == C_MERA) dirty = 1'b0;
        rd_reg(A_STAT, v);
        chk($sformatf("R9 d=%0d i=%0d", d, i), v,
            (seq[i] == C_VER && !dirty) ? 'h44 : 'h40);
      end
    end
    wr_reg(A_STAT, 16'h0004);
    rd_reg(A_STAT, v); chk("R8 blank clear", v, 'h40);

    // R5 sector sweep
    wr_reg(A_DIV, 16'h0000);
    for (int p = 0; p < 8; p++) begin
      wr_reg(A_PRA, 16'(1 << p));
      for (int s = 0; s < 8; s++) begin
        prep((s % 2) ? C_PERA : C_PROG, 7'(s * 16 + 3));
        launch_measure(n);
        rd_reg(A_STAT, v);
        if (s == p) begin
          chk($sformatf("R5 hit p=%0d", p), v, 'h60);
          wr_reg(A_STAT, 16'h0020);
        end else begin
          chk($sformatf("R5 miss p=%0d s=%0d", p, s), n, TICKS);
        end
      end
    end
    // R5 mass erase guarded by either register
    wr_reg(A_PRA, 16'h0000);
    wr_reg(A_PRB, 16'h0001);
    prep(C_MERA, 7'h00);
    launch_measure(n);
    rd_reg(A_STAT, v); chk("R5 mass prot B", v, 'h60);
    wr_reg(A_STAT, 16'h0020);
    wr_reg(A_PRB, 16'h0000);
    launch_measure(n); chk("R5 unprotected", n, TICKS);
    rd_reg(A_STAT, v); chk("R5 unprotected status", v, 'h40);

    // R7 restart while busy
    wr_reg(A_DIV, 16'h0002);
    prep(C_PROG, 7'h11);
    wr_reg(A_STAT, 16'h0080);
    addr = A_STAT; #1;
    n = 0;
    while (!rdata[6] && n < 2000) begin
      n++;
      wr = (n == 3); wdata = 16'h0080;
      @(negedge clk); #1;
    end
    wr = 1'b0;
    chk("R7 length", n, TICKS * 3);
    rd_reg(A_STAT, v); chk("R7 flags", v, 'h40);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule